// File: doc/BRIEF.md
# Read-Sequence Write-Lock Detector

This block watches the read strobes and address of a byte-wide nonvolatile memory bus and maintains a write-lock flag. A host unlocks the memory by issuing seven back-to-back reads at a fixed list of addresses. It locks it again with a second list that begins with the same six addresses and ends with a different seventh one. No data is involved: the key is the order of read addresses, and the data pins are not an input of the block.

The bus strobes are active-low: chip select, output enable and write enable. They and the address pass through a two-stage synchronizer into the fast system clock. A read is in progress while chip select and output enable are both low. It ends on the first sampled cycle in which either strobe is high, and the address held from the last active cycle is the one judged. A write cycle has chip select and write enable low with output enable high. Any write, including a command abort, discards the progress of a sequence and leaves the flag alone.

The state machine has states ST_IDLE and ST_M1 to ST_M6, where the number is the count of matching reads so far. Its transitions are:
- ADVANCE: a matching read moves to the next state.
- RESTART: a wrong address that equals the first key address goes to ST_M1.
- DROP: any other wrong address goes to ST_IDLE.
- COMMIT: the seventh read in ST_M6 updates the flag and goes to ST_IDLE.
- CANCEL: a write goes to ST_IDLE.

Top module: `rdseq_guard`

## Requirements
- R1: While reset is asserted and right after it, lock_o is 1 and step_o is 0.
- R2: Seven reads at 01823h, 01820h, 01822h, 00418h, 0041Bh, 00419h, 0041Ah in that order drive lock_o to 0.
- R3: Seven reads whose first six addresses match R2 and whose seventh is at 0040Ah drive lock_o to 1.
- R4: The address of a read is the one present when the read ends, whether chip select or output enable rises first. Address changes after that point, including while output enable stays low with chip select high, have no effect.
- R5: A read at an address that is not the next expected one sets step_o to 0, or to 1 if the address is 01823h.
- R6: A write cycle (csn_i=0, wen_i=0, oen_i=1) sets step_o to 0 and leaves lock_o unchanged, so the rest of the sequence no longer completes.
- R7: step_o reports the number of matching reads so far (0 to 6), and lock_o changes only when the seventh read completes.
- R8: If a read ends in the same sampled cycle that a write begins, the write wins for progress and step_o becomes 0. A seventh matching read still commits its flag value in that cycle.
- R9: After a seventh read, step_o is 0. A seventh read at any other address leaves lock_o unchanged, and repeating a sequence that matches the current flag value leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Bus chip select, active low |
| oen_i | input | 1 | Bus output enable, active low |
| wen_i | input | 1 | Bus write enable, active low |
| addr_i | input | 19 | Bus address |
| lock_o | output | 1 | Write-lock flag, 1 = writes blocked |
| step_o | output | 3 | Count of matching reads in the current sequence |

## Verification
A read ending and a write starting can land in the same sampled cycle. This happens when chip select stays low while output enable rises and write enable falls at the same instant. The bench provokes this at step 6, where it expects the flag to change and step_o to return to 0. It provokes it again at step 2, where it expects step_o 0 and an unchanged flag. The checker also requires step_o to be 0 one cycle after any synchronized write.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
    localparam int ADDR_W  = 19;
    localparam int KEY_LEN = 7;
    localparam int STEP_W  = $clog2(KEY_LEN);

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE = 3'd0,
        ST_M1   = 3'd1,
        ST_M2   = 3'd2,
        ST_M3   = 3'd3,
        ST_M4   = 3'd4,
        ST_M5   = 3'd5,
        ST_M6   = 3'd6
    } seq_st_e;

    localparam logic [ADDR_W-1:0] KEY_UNLOCK_LAST = 19'h0041A;
    localparam logic [ADDR_W-1:0] KEY_LOCK_LAST   = 19'h0040A;

    // shared prefix of both sequences, step index 0..5
    function automatic logic [ADDR_W-1:0] key_prefix(input logic [STEP_W-1:0] idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            3'd0:    a = 19'h01823;
            3'd1:    a = 19'h01820;
            3'd2:    a = 19'h01822;
            3'd3:    a = 19'h00418;
            3'd4:    a = 19'h0041B;
            3'd5:    a = 19'h00419;
            default: a = '1;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/rdseq_sync.sv
module rdseq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= RST_VAL;
            end else begin
                if (s == 0) chain[s] <= d_i;
                else        chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rdseq_cycle.sv
module rdseq_cycle
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              oen_s,
    input  logic              wen_s,
    input  logic [ADDR_W-1:0] addr_s,
    output logic              rd_end_o,
    output logic              wr_act_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    logic rd_act;
    logic rd_act_q;
    logic [ADDR_W-1:0] addr_hold;

    assign rd_act = ~csn_s & ~oen_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_act_q  <= 1'b0;
            addr_hold <= '0;
        end else begin
            rd_act_q <= rd_act;
            if (rd_act) addr_hold <= addr_s;
        end
    end

    assign rd_end_o  = rd_act_q & ~rd_act;
    assign wr_act_o  = ~csn_s & ~wen_s & oen_s;
    assign rd_addr_o = addr_hold;
endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_end_i,
    input  logic              wr_act_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              lock_o,
    output logic [STEP_W-1:0] step_o
);
    seq_st_e st_q, st_d;
    logic    set_lock, clr_lock;
    logic    is_first;

    assign is_first = (rd_addr_i == key_prefix(3'd0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d     = st_q;
        set_lock = 1'b0;
        clr_lock = 1'b0;
        if (rd_end_i) begin
            unique case (st_q)
                ST_IDLE, ST_M1, ST_M2, ST_M3, ST_M4, ST_M5: begin
                    if (rd_addr_i == key_prefix(st_q)) st_d = seq_st_e'(st_q + 3'd1); // ADVANCE
                    else if (is_first)                   st_d = ST_M1;                  // RESTART
                    else                                 st_d = ST_IDLE;                // DROP
                end
                ST_M6: begin
                    if (rd_addr_i == KEY_UNLOCK_LAST) begin                             // COMMIT
                        clr_lock = 1'b1;
                        st_d     = ST_IDLE;
                    end else if (rd_addr_i == KEY_LOCK_LAST) begin                      // COMMIT
                        set_lock = 1'b1;
                        st_d     = ST_IDLE;
                    end else if (is_first) begin
                        st_d = ST_M1;                                                   // RESTART
                    end else begin
                        st_d = ST_IDLE;                                                 // DROP
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
        if (wr_act_i) st_d = ST_IDLE;                                                   // CANCEL
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lock_o <= 1'b1;
        else if (set_lock) lock_o <= 1'b1;
        else if (clr_lock) lock_o <= 1'b0;
    end

    assign step_o = st_q;
endmodule

// File: rtl/rdseq_guard.sv
module rdseq_guard
    import rdseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              oen_i,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              lock_o,
    output logic [STEP_W-1:0] step_o
);
    localparam int BUS_W = ADDR_W + 3;

    logic [BUS_W-1:0] bus_raw, bus_s;
    logic             rd_end, wr_act;
    logic [ADDR_W-1:0] rd_addr;

    assign bus_raw = {csn_i, oen_i, wen_i, addr_i};

    rdseq_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({3'b111, {ADDR_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_raw),
        .q_o   (bus_s)
    );

    rdseq_cycle u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (bus_s[BUS_W-1]),
        .oen_s     (bus_s[BUS_W-2]),
        .wen_s     (bus_s[BUS_W-3]),
        .addr_s    (bus_s[ADDR_W-1:0]),
        .rd_end_o  (rd_end),
        .wr_act_o  (wr_act),
        .rd_addr_o (rd_addr)
    );

    rdseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_end_i  (rd_end),
        .wr_act_i  (wr_act),
        .rd_addr_i (rd_addr),
        .lock_o    (lock_o),
        .step_o    (step_o)
    );
endmodule

// File: rtl/rdseq_guard_chk.sv
module rdseq_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lock_o,
    input logic [2:0] step_o,
    input logic       wr_act
);
    AST_RESET_LOCKED: assert property (@(posedge clk) !rst_n |=> (lock_o && step_o == 3'd0)); // R1
    AST_FLAG_AT_SEVENTH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_o) |-> $past(step_o) == 3'd6); // R7
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_o) |-> (step_o == $past(step_o) + 3'd1 || step_o <= 3'd1)); // R5
    AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> step_o == 3'd0); // R6
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o <= 3'd6); // R7
endmodule

bind rdseq_guard rdseq_guard_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_o (lock_o),
    .step_o (step_o),
    .wr_act (wr_act)
);

// File: tb/rdseq_guard_bench.sv
module rdseq_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, oen = 1'b1, wen = 1'b1;
    logic [18:0] addr = '0;
    logic        lock;
    logic [2:0]  step;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [18:0] K0 = 19'h01823, K1 = 19'h01820, K2 = 19'h01822,
                            K3 = 19'h00418, K4 = 19'h0041B, K5 = 19'h00419,
                            K_UNL = 19'h0041A, K_LCK = 19'h0040A;

    always #2 clk = ~clk;

    rdseq_guard u_rdseq_guard (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .oen_i(oen), .wen_i(wen),
        .addr_i(addr), .lock_o(lock), .step_o(step)
    );

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // read ending either by chip select or by output enable first; address scrambled after
    task automatic rd(input logic [18:0] a, input bit cs_first);
        @(negedge clk);
        addr = a; csn = 1'b0; oen = 1'b0;
        idle(4);
        if (cs_first) begin
            csn = 1'b1; addr = 19'h7FFFF;
            idle(3);
            oen = 1'b1;
        end else begin
            oen = 1'b1; addr = 19'h7FFFF;
            idle(3);
            csn = 1'b1;
        end
        idle(6);
    endtask

    task automatic wr();
        @(negedge clk);
        csn = 1'b0; wen = 1'b0; oen = 1'b1; addr = 19'h00555;
        idle(4);
        csn = 1'b1; wen = 1'b1;
        idle(6);
    endtask

    task automatic prefix(input int n);
        logic [18:0] keys [6];
        keys = '{K0, K1, K2, K3, K4, K5};
        for (int i = 0; i < n; i++) rd(keys[i], i[0]);
    endtask

    task automatic t_reset();
        check("R1 lock after reset", 4'(lock), 4'd1);
        check("R1 step after reset", 4'(step), 4'd0);
    endtask

    task automatic t_unlock();
        logic [18:0] keys [6];
        keys = '{K0, K1, K2, K3, K4, K5};
        for (int i = 0; i < 6; i++) begin
            rd(keys[i], 1'b0);
            check("R7 step count", 4'(step), 4'(i + 1));
            check("R7 lock held mid-sequence", 4'(lock), 4'd1);
        end
        rd(K_UNL, 1'b0);
        check("R2 unlocked", 4'(lock), 4'd0);
        check("R9 step after seventh", 4'(step), 4'd0);
    endtask

    task automatic t_lock();
        prefix(6);
        rd(K_LCK, 1'b1);
        check("R3 locked again", 4'(lock), 4'd1);
    endtask

    task automatic t_capture();
        rd(K0, 1'b1);
        // chip select high, output enable low, key address shown: not a read
        @(negedge clk);
        oen = 1'b0; addr = K1;
        idle(6);
        oen = 1'b1;
        idle(4);
        check("R4 non-read ignored", 4'(step), 4'd1);
        rd(K1, 1'b0); rd(K2, 1'b1); rd(K3, 1'b0); rd(K4, 1'b1); rd(K5, 1'b0);
        rd(K_UNL, 1'b1);
        check("R4 mixed ends unlock", 4'(lock), 4'd0);
    endtask

    task automatic t_mismatch();
        prefix(3);
        rd(19'h00123, 1'b0);
        check("R5 mismatch to idle", 4'(step), 4'd0);
        prefix(2);
        rd(K0, 1'b0);
        check("R5 mismatch restarts", 4'(step), 4'd1);
        rd(K1, 1'b1);
        check("R5 continues after restart", 4'(step), 4'd2);
    endtask

    task automatic t_write_cancel();
        idle(2); wr(); // clear leftover progress
        prefix(4);
        wr();
        check("R6 write clears step", 4'(step), 4'd0);
        check("R6 write keeps lock", 4'(lock), 4'd0);
        rd(K4, 1'b0); rd(K5, 1'b0); rd(K_LCK, 1'b0);
        check("R6 tail does not complete", 4'(lock), 4'd0);
    endtask

    task automatic read_then_write(input logic [18:0] a);
        @(negedge clk);
        addr = a; csn = 1'b0; oen = 1'b0;
        idle(4);
        oen = 1'b1; wen = 1'b0; // read ends and write starts together
        idle(4);
        wen = 1'b1; csn = 1'b1;
        idle(6);
    endtask

    task automatic t_same_cycle();
        prefix(2);
        read_then_write(K2);
        check("R8 mid-step collision", 4'(step), 4'd0);
        check("R8 mid-step lock kept", 4'(lock), 4'd0);
        prefix(6);
        read_then_write(K_LCK);
        check("R8 seventh commits", 4'(lock), 4'd1);
        check("R8 step cleared", 4'(step), 4'd0);
    endtask

    task automatic t_other_seventh();
        prefix(6);
        rd(K5, 1'b0);
        check("R9 odd seventh keeps lock", 4'(lock), 4'd1);
        check("R9 odd seventh step", 4'(step), 4'd0);
        prefix(6);
        rd(K_LCK, 1'b0);
        check("R9 repeat lock stays", 4'(lock), 4'd1);
    endtask

    initial begin
        idle(5);
        t_reset();
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_unlock();
        t_lock();
        t_capture();
        t_mismatch();
        t_write_cancel();
        t_same_cycle();
        t_other_seventh();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule